// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is the arbitration front end of a shared scratchpad split into 32 banks of 32-bit words. A batch of up to 32 lane requests arrives in one cycle, each request being a per-lane valid bit and a word address. The block maps every address to its bank and works out how many bank-conflict-free cycles the batch needs. It then hands out per-lane grants, one conflict-free group per cycle, until every valid lane has been served. The bank RAMs and the write data paths sit outside this block.

Lanes that read the same word of a bank are granted in the same cycle, as a broadcast, and add nothing to the conflict count. Within each cycle, for every bank, the lowest-numbered lane still waiting decides which word that bank serves. The number of cycles the batch needs is reported on a degree output as soon as the batch is taken. While the block is busy it ignores new batches.

Top module: `bank_conflict_serializer`

## Requirements
- R1: The bank of a lane is its word address modulo 32 (the low five address bits). Lanes in different banks are granted in the same cycle, and lanes whose words are 32 apart share a bank and are never granted together.
- R2: Lanes 0..31 at addresses base+0..base+31 (stride 1) are all granted in one cycle, and degree reads 1.
- R3: The degree and the number of grant cycles both equal the largest count of distinct words mapped to any one bank; for example stride 2 needs 2 cycles and stride 8 needs 8. Every cycle of a busy period grants at least one lane.
- R4: Any batch that places each lane in a distinct bank, in any order, completes in one cycle.
- R5: Column access with stride 33 (a padded 32-word row) completes in one cycle.
- R6: Lanes that request the same word are granted in the same cycle and that word counts once toward the degree; all lanes at one address give degree 1.
- R7: In each grant cycle, for each bank, the lowest-numbered lane not yet granted picks the word served; all waiting lanes at that word are granted with it, and no two lanes at different words of one bank are granted together.
- R8: Each valid lane is granted exactly once per batch, invalid lanes are never granted, and a batch with no valid lane gives degree 0 and no grants.
- R9: A batch is taken on a clock edge where in_valid is 1 and busy is 0. From the next cycle busy is 1 if degree is non-zero, grants appear on the cycles after that (gnt_valid=1), and busy returns to 0 in the cycle that shows the last grant. in_valid while busy is ignored.
- R10: After reset busy, gnt_valid, gnt and degree are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offers a new batch of requests |
| lane_valid | input | LANES | Per-lane request valid |
| lane_addr | input | LANES*AW | Per-lane word address, lane i at bits i*AW +: AW |
| busy | output | 1 | A batch is still being served |
| gnt_valid | output | 1 | gnt holds the lanes served this cycle |
| gnt | output | LANES | Per-lane grant for the current cycle |
| degree | output | $clog2(LANES+1) | Number of grant cycles the accepted batch needs |

## Verification
On every cycle the assertions check that two lanes granted together never sit in one bank at different words, that grants fall only on lanes still waiting, that each busy cycle retires at least one lane, that a new offer leaves degree untouched while busy, and that the count of grant cycles matches the reported degree when busy drops. Which lanes go together in each cycle, the lowest-lane tie rule, the exact degree for strides, permutations, padded columns, broadcasts and masked lanes, and the reset values can only be shown by the bench, which sweeps strides 0 to 40, all odd-multiplier bank permutations and many pseudo-random batches against an arithmetic model.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // width needed to hold a count from 0 to n
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bcs_bank_map.sv
module bcs_bank_map #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 10,
  localparam int unsigned BW   = $clog2(BANKS)
) (
  input  logic [LANES*AW-1:0] addr,
  output logic [LANES*BW-1:0] bank
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bank[i*BW +: BW] = BW'(addr[i*AW +: AW] % AW'(BANKS));
  end
endmodule

// File: rtl/bcs_degree_calc.sv
module bcs_degree_calc #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned BW    = 5,
  parameter int unsigned DW    = 6
) (
  input  logic [LANES-1:0]    valid,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*BW-1:0] bank,
  output logic [DW-1:0]       degree
);
  logic [LANES-1:0] first_use;

  // a lane counts only if no lower valid lane already names its word
  always_comb begin
    first_use = valid;
    for (int i = 1; i < LANES; i++)
      for (int j = 0; j < i; j++)
        if (valid[j] && addr[j*AW +: AW] == addr[i*AW +: AW])
          first_use[i] = 1'b0;
  end

  always_comb begin
    logic [DW-1:0] cnt;
    degree = '0;
    for (int b = 0; b < BANKS; b++) begin
      cnt = '0;
      for (int i = 0; i < LANES; i++)
        if (first_use[i] && bank[i*BW +: BW] == BW'(b))
          cnt = cnt + DW'(1);
      if (cnt > degree) degree = cnt;
    end
  end
endmodule

// File: rtl/bcs_grant_pick.sv
module bcs_grant_pick #(
  parameter int unsigned LANES = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned BW    = 5
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*BW-1:0] bank,
  output logic [LANES-1:0]    served
);
  logic [LANES-1:0] leader;

  // leader: lowest pending lane of its bank
  always_comb begin
    leader = pend;
    for (int i = 1; i < LANES; i++)
      for (int j = 0; j < i; j++)
        if (pend[j] && bank[j*BW +: BW] == bank[i*BW +: BW])
          leader[i] = 1'b0;
  end

  // every pending lane at a leader's word rides along
  always_comb begin
    served = '0;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < LANES; j++)
        if (leader[j] && addr[j*AW +: AW] == addr[i*AW +: AW])
          served[i] = pend[i];
  end
endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 10
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic [LANES-1:0]                       lane_valid,
  input  logic [LANES*AW-1:0]                    lane_addr,
  output logic                                   busy,
  output logic                                   gnt_valid,
  output logic [LANES-1:0]                       gnt,
  output logic [bcs_pkg::count_width(LANES)-1:0] degree
);
  localparam int unsigned BW = $clog2(BANKS);
  localparam int unsigned DW = bcs_pkg::count_width(LANES);

  logic [LANES-1:0]    pend;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*BW-1:0] bank_in, bank_q;
  logic [LANES-1:0]    served;
  logic [DW-1:0]       deg_c;
  logic [DW-1:0]       cyc;
  logic                accept;

  bcs_bank_map #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u_map_in (
    .addr(lane_addr), .bank(bank_in));
  bcs_bank_map #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u_map_q (
    .addr(addr_q), .bank(bank_q));

  bcs_degree_calc #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .BW(BW), .DW(DW)) u_deg (
    .valid(lane_valid), .addr(lane_addr), .bank(bank_in), .degree(deg_c));

  bcs_grant_pick #(.LANES(LANES), .AW(AW), .BW(BW)) u_pick (
    .pend(pend), .addr(addr_q), .bank(bank_q), .served(served));

  assign busy   = |pend;
  assign accept = in_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      addr_q    <= '0;
      gnt       <= '0;
      gnt_valid <= 1'b0;
      degree    <= '0;
      cyc       <= '0;
    end else if (accept) begin
      pend      <= lane_valid;
      addr_q    <= lane_addr;
      degree    <= deg_c;
      cyc       <= '0;
      gnt       <= '0;
      gnt_valid <= 1'b0;
    end else if (busy) begin
      pend      <= pend & ~served;
      gnt       <= served;
      gnt_valid <= 1'b1;
      cyc       <= cyc + DW'(1);
    end else begin
      gnt       <= '0;
      gnt_valid <= 1'b0;
    end
  end

  // pairs of granted lanes in one bank at different words
  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (gnt[i] && gnt[j] && bank_q[i*BW +: BW] == bank_q[j*BW +: BW] &&
            addr_q[i*AW +: AW] != addr_q[j*AW +: AW])
          clash = 1'b1;
  end

  // R7
  one_word_per_bank_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> !clash);

  // R8
  grant_was_pending_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ((gnt & ~$past(pend)) == '0));

  // R9
  no_grant_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> $past(busy));

  // R3
  progress_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(pend) < $countones($past(pend))));

  // R3
  cycles_match_degree_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cyc == degree));

  // R9
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && in_valid) |=> $stable(degree));
endmodule

// File: tb/bank_conflict_serializer_test.sv
module bank_conflict_serializer_test;
  localparam int LANES = 32;
  localparam int AW    = 10;
  localparam int DW    = $clog2(LANES + 1);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic [LANES-1:0]    lane_valid = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic                busy, gnt_valid;
  logic [LANES-1:0]    gnt;
  logic [DW-1:0]       degree;

  bank_conflict_serializer #(.LANES(LANES), .BANKS(32), .AW(AW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_valid(lane_valid),
    .lane_addr(lane_addr), .busy(busy), .gnt_valid(gnt_valid), .gnt(gnt),
    .degree(degree));

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int unsigned ta [LANES];
  logic [LANES-1:0] tv;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_degree();
    int best = 0;
    for (int b = 0; b < 32; b++) begin
      int cnt = 0;
      for (int i = 0; i < LANES; i++) begin
        bit dup = 0;
        if (!tv[i] || (ta[i] % 32) != b) continue;
        for (int j = 0; j < i; j++) if (tv[j] && ta[j] == ta[i]) dup = 1;
        if (!dup) cnt++;
      end
      if (cnt > best) best = cnt;
    end
    return best;
  endfunction

  function automatic logic [LANES-1:0] ref_round(input logic [LANES-1:0] p);
    logic [LANES-1:0] r = '0;
    for (int i = 0; i < LANES; i++) begin
      int lead = -1;
      if (!p[i]) continue;
      for (int j = 0; j < LANES; j++)
        if (lead < 0 && p[j] && (ta[j] % 32) == (ta[i] % 32)) lead = j;
      if (ta[lead] == ta[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic run_case(input string tag, input bit poke);
    int exp_d;
    logic [LANES-1:0] p, e;
    bit first = 1;
    exp_d = ref_degree();
    @(negedge clk);
    lane_valid = tv;
    for (int i = 0; i < LANES; i++) lane_addr[i*AW +: AW] = AW'(ta[i]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      in_valid   = 1'b1;
      lane_valid = '1;
      lane_addr  = '0;
    end
    chk(degree == DW'(exp_d), tag, "degree", degree, exp_d);
    chk(busy == (exp_d != 0), "R9", "busy after accept", busy, exp_d != 0);
    p = tv;
    while (p != '0) begin
      e = ref_round(p);
      p = p & ~e;
      @(negedge clk);
      if (first && poke) in_valid = 1'b0;
      first = 0;
      chk(gnt_valid && gnt == e, "R7", "grant set", gnt, e);
    end
    chk(!busy, "R9", "busy after last grant", busy, 0);
    if (poke) chk(degree == DW'(exp_d), "R9", "degree held", degree, exp_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R9", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !gnt_valid && gnt == '0 && degree == '0, "R10", "reset outputs",
        {busy, gnt_valid, gnt}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !gnt_valid, "R10", "idle after reset", busy, 0);

    // strides 0..40, all lanes: R2 (1), R3, R5 (33), R6 (0)
    for (int s = 0; s <= 40; s++) begin
      tv = '1;
      for (int i = 0; i < LANES; i++) ta[i] = (7 + i * s) % 1024;
      run_case(s == 1 ? "R2" : s == 33 ? "R5" : s == 0 ? "R6" : "R3", 0);
    end

    // R4 bank permutations, each lane in a different row
    for (int m = 1; m < 32; m += 2) begin
      tv = '1;
      for (int i = 0; i < LANES; i++) ta[i] = ((i * m + 3) % 32) + 32 * (i % 16);
      run_case("R4", 0);
    end

    // R1 distinct banks, rows 32 apart; then one bank only
    tv = '1;
    for (int i = 0; i < LANES; i++) ta[i] = 33 * i;
    run_case("R1", 0);
    for (int i = 0; i < LANES; i++) ta[i] = 32 * i;
    run_case("R1", 0);

    // R6 two broadcast groups in one bank
    for (int i = 0; i < LANES; i++) ta[i] = (i < 16) ? 5 : 37;
    run_case("R6", 0);

    // R7 lowest lane picks the word
    tv = '0; tv[3] = 1; tv[5] = 1; tv[9] = 1;
    for (int i = 0; i < LANES; i++) ta[i] = 0;
    ta[3] = 64; ta[5] = 0; ta[9] = 64;
    run_case("R7", 0);

    // R8 masked lanes carry conflicting addresses
    tv = 32'h0000_FFFF;
    for (int i = 0; i < LANES; i++) ta[i] = (i < 16) ? i : 32 * i;
    run_case("R8", 0);
    tv = '0;
    run_case("R8", 0);

    // R9 new offer while busy is ignored
    tv = '1;
    for (int i = 0; i < LANES; i++) ta[i] = 4 * i;
    run_case("R9", 1);

    // R1 R3 R6 R8 pseudo-random batches
    for (int k = 0; k < 300; k++) begin
      tv = rnd();
      if (k % 3 == 0) tv = '1;
      for (int i = 0; i < LANES; i++) ta[i] = rnd() % ((k % 4 == 0) ? 1024 : 96);
      run_case("R3", 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule